// File: doc/BRIEF.md
# Shared-Buffer Cell Queue Manager

This block does the bookkeeping for a cell store of 512 slots that is shared by eight output queues. Each queue has four delay priorities, and each (queue, priority) pair keeps its own linked list of slot indices. The store is not split between queues. Any slot can hold a cell for any queue. Free slots are kept on a free list.

An enqueue request gives a destination bitmap and a priority. The block admits the cell to every requested queue that is still below its dynamic threshold, takes a single slot for it, and links that slot into the list of each accepting queue. The writer then stores the payload in the returned slot. The slot has a reference count equal to the number of queues that took the cell, so a multicast cell is stored once. A dequeue request names a queue and a priority. It returns the head slot of that list and lowers the count. When the count reaches zero, the slot goes back on the free list.

Control is a three-state machine. BUILD threads all slots onto the free list, one slot per cycle. The BUILD→RUN transition fires when the last slot has been threaded. RUN serves one request per cycle. The RUN→HALT transition fires on any linked-list fault. HALT serves nothing and can only be left through reset. If an enqueue and a dequeue arrive in the same cycle, the enqueue is served and the dequeue is dropped.

Top module: `cellq_mgr`

## Requirements
- R1: After reset the block is in BUILD for exactly 512 cycles with `ready` low. When `ready` rises, the free count is 512, all queue lengths and the drop count are zero, and the first allocations return slots 0, 1, 2 … in ascending order.
- R2: One cycle after an enqueue request in RUN, `enq_done` pulses and `enq_acc` gives the accepted subset of `enq_dest` (bit q = queue q). If that subset is non-empty, `enq_slot` is the slot taken from the head of the free list. The free count drops by exactly one however many queues accepted the cell.
- R3: Queue q accepts a cell only if its length is below its threshold. The threshold is the free count shifted left by `share_shift` when `share_shift` is 0 to 2, or shifted right by −`share_shift` (rounded down) when `share_shift` is −2 to −1. `share_shift` is two's complement.
- R4: The drop counter rises by one for each enqueue request in which at least one requested queue refused the cell. An enqueue that no queue accepted leaves the free count and all queue lengths unchanged.
- R5: Each (queue, priority) list is first in, first out. Lists of different priorities in the same queue do not affect each other.
- R6: One cycle after a dequeue request to a non-empty list, `deq_done` and `deq_ok` are high, `deq_slot` is the oldest slot of that list, and that queue's length drops by one.
- R7: A slot returns to the free list only when the last queue holding it dequeues it. Returned slots join the tail of the free list, so they are reused only after every slot that was already free.
- R8: The fault flag stays low under legal traffic. Internally it is raised if the free count exceeds 512 or if the free list has no head while its count is non-zero.
- R9: A dequeue from an empty list gives `deq_done` with `deq_ok` low one cycle later, with `fault` set in the same cycle. The block then stays in HALT: later requests get no response and change no count.
- R10: `used_count` equals 512 minus `free_count`. `queue_len` gives the length of each queue, with queue q in bits [10q+9:10q].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| share_shift | input | 3 | Signed threshold shift, −2..2 |
| enq_valid | input | 1 | Enqueue request strobe |
| enq_dest | input | 8 | Destination queue bitmap |
| enq_pri | input | 2 | Priority of the enqueued cell |
| enq_done | output | 1 | Enqueue response strobe |
| enq_acc | output | 8 | Queues that accepted the cell |
| enq_slot | output | 9 | Slot holding the accepted cell |
| deq_valid | input | 1 | Dequeue request strobe |
| deq_queue | input | 3 | Queue to dequeue from |
| deq_pri | input | 2 | Priority list to dequeue from |
| deq_done | output | 1 | Dequeue response strobe |
| deq_ok | output | 1 | List was non-empty |
| deq_slot | output | 9 | Dequeued slot |
| ready | output | 1 | Block is in RUN |
| fault | output | 1 | Linked-list fault, held until reset |
| free_count | output | 10 | Slots on the free list |
| used_count | output | 10 | Slots in use |
| queue_len | output | 80 | Per-queue lengths, 10 bits each |
| drop_count | output | 16 | Enqueues with a refused destination |

## Verification
The assertions assume that `share_shift` stays in −2..2, and one of them checks that assumption. The only other input assumption is the one-request-per-cycle rule, which the block enforces itself by serving the enqueue first. The stimulus drives at most one request per cycle and uses only the shift values −2, 0 and 2. The one illegal dequeue is issued last, so the HALT state can be observed without ending the earlier scenarios. The bench keeps its own free-list order, per-list FIFOs, reference counts and thresholds, and predicts every slot number and acceptance mask from them.

// File: rtl/cellq_pkg.sv
package cellq_pkg;
    typedef enum logic [1:0] {
        ST_BUILD = 2'd0,
        ST_RUN   = 2'd1,
        ST_HALT  = 2'd2
    } qm_state_e;

    // Largest magnitude of the threshold shift.
    localparam int SHIFT_SPAN = 2;
endpackage

// File: rtl/cellq_ctrl.sv
module cellq_ctrl
    import cellq_pkg::*;
#(
    parameter int NUM_SLOTS = 512,
    localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault_in,
    output logic              build_push,
    output logic [SLOT_W-1:0] build_slot,
    output logic              run,
    output logic              halted
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

    qm_state_e         state, state_nx;
    logic [SLOT_W-1:0] bcnt;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_BUILD;
        else        state <= state_nx;
    end

    // Build walker: threads one slot per cycle
    always_ff @(posedge clk) begin
        if (!rst_n)                 bcnt <= '0;
        else if (state == ST_BUILD) bcnt <= bcnt + SLOT_W'(1);
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_BUILD: if (bcnt == LAST_SLOT) state_nx = ST_RUN;
            ST_RUN:   if (fault_in)          state_nx = ST_HALT;
            ST_HALT:                         state_nx = ST_HALT;
            default:                         state_nx = ST_HALT;
        endcase
    end

    // Outputs
    always_comb begin
        build_push = 1'b0;
        run        = 1'b0;
        halted     = 1'b0;
        unique case (state)
            ST_BUILD: build_push = 1'b1;
            ST_RUN:   run        = 1'b1;
            ST_HALT:  halted     = 1'b1;
            default:  halted     = 1'b1;
        endcase
    end
    assign build_slot = bcnt;

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |=> (state == ST_HALT)); // R9
    AST_BUILD_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUILD && bcnt != LAST_SLOT) |=> (state == ST_BUILD)); // R1
endmodule

// File: rtl/cellq_freelist.sv
module cellq_freelist #(
    parameter int NUM_SLOTS = 512,
    localparam int SLOT_W = $clog2(NUM_SLOTS),
    localparam int CNT_W  = $clog2(NUM_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [SLOT_W-1:0] push_slot,
    input  logic              pop,
    output logic [SLOT_W-1:0] head,
    output logic [CNT_W-1:0]  cnt,
    output logic              err
);
    localparam logic [CNT_W-1:0] SLOTS_C = CNT_W'(NUM_SLOTS);

    logic [SLOT_W-1:0] link [NUM_SLOTS];
    logic [SLOT_W-1:0] tail;
    logic              head_vld;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head     <= '0;
            tail     <= '0;
            cnt      <= '0;
            head_vld <= 1'b0;
        end else if (push) begin
            if (!head_vld) head <= push_slot;
            head_vld <= 1'b1;
            tail     <= push_slot;
            cnt      <= cnt + CNT_W'(1);
        end else if (pop) begin
            head <= link[head];
            cnt  <= cnt - CNT_W'(1);
            if (cnt == CNT_W'(1)) head_vld <= 1'b0;
        end
    end

    // Link storage, no reset
    always_ff @(posedge clk) begin
        if (push && head_vld) link[tail] <= push_slot;
    end

    assign err = ((cnt != '0) && !head_vld) || (cnt > SLOTS_C);

    AST_POP_HAS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt != '0)); // R2
    AST_FREE_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= SLOTS_C); // R8
    AST_NO_PUSH_POP: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop)); // R7
endmodule

// File: rtl/cellq_admit.sv
module cellq_admit #(
    parameter int NUM_Q = 8,
    parameter int CNT_W = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CNT_W-1:0]       free_cnt,
    input  logic signed [2:0]      share_shift,
    input  logic [NUM_Q*CNT_W-1:0] qlen_flat,
    input  logic [NUM_Q-1:0]       dest,
    output logic [NUM_Q-1:0]       acc
);
    localparam int TW = CNT_W + cellq_pkg::SHIFT_SPAN;

    logic [TW-1:0] thr;
    logic [2:0]    amt;

    // Pre-scale by the maximum left shift, then shift right by the remainder.
    always_comb begin
        amt = 3'(cellq_pkg::SHIFT_SPAN) - share_shift;
        thr = {free_cnt, {cellq_pkg::SHIFT_SPAN{1'b0}}} >> amt;
    end

    for (genvar g = 0; g < NUM_Q; g++) begin : g_q
        logic [CNT_W-1:0] len;
        assign len    = qlen_flat[g*CNT_W +: CNT_W];
        assign acc[g] = dest[g] && ({{cellq_pkg::SHIFT_SPAN{1'b0}}, len} < thr);
    end

    AST_SHIFT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (share_shift >= -3'sd2) && (share_shift <= 3'sd2)); // R3
endmodule

// File: rtl/cellq_links.sv
module cellq_links #(
    parameter int NUM_SLOTS = 512,
    parameter int NUM_Q     = 8,
    parameter int NUM_PRI   = 4,
    localparam int SLOT_W = $clog2(NUM_SLOTS),
    localparam int CNT_W  = $clog2(NUM_SLOTS + 1),
    localparam int Q_W    = $clog2(NUM_Q),
    localparam int P_W    = $clog2(NUM_PRI),
    localparam int RC_W   = $clog2(NUM_Q + 1),
    localparam int NLIST  = NUM_Q * NUM_PRI
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   enq_fire,
    input  logic [SLOT_W-1:0]      enq_slot,
    input  logic [NUM_Q-1:0]       enq_acc,
    input  logic [P_W-1:0]         enq_pri,
    input  logic                   deq_fire,
    input  logic [Q_W-1:0]         deq_q,
    input  logic [P_W-1:0]         deq_p,
    output logic [SLOT_W-1:0]      deq_head,
    output logic                   deq_empty,
    output logic                   release_slot,
    output logic [NUM_Q*CNT_W-1:0] qlen_flat
);
    localparam logic [CNT_W-1:0] SLOTS_C = CNT_W'(NUM_SLOTS);

    logic [SLOT_W-1:0] qnxt [NUM_Q][NUM_SLOTS];
    logic [RC_W-1:0]   refc [NUM_SLOTS];
    logic [SLOT_W-1:0] lhead [NLIST];
    logic [SLOT_W-1:0] ltail [NLIST];
    logic [CNT_W-1:0]  lcnt  [NLIST];
    logic [CNT_W-1:0]  qlen  [NUM_Q];
    logic [RC_W-1:0]   fanout;
    int unsigned       dli;

    always_comb begin
        dli          = int'(deq_q) * NUM_PRI + int'(deq_p);
        deq_head     = lhead[dli];
        deq_empty    = (lcnt[dli] == '0);
        release_slot = deq_fire && (refc[deq_head] == RC_W'(1));
        fanout       = RC_W'($countones(enq_acc));
    end

    // List pointers and lengths
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NLIST; i++) begin
                lhead[i] <= '0;
                ltail[i] <= '0;
                lcnt[i]  <= '0;
            end
            for (int q = 0; q < NUM_Q; q++) qlen[q] <= '0;
        end else begin
            if (enq_fire) begin
                for (int q = 0; q < NUM_Q; q++) begin
                    if (enq_acc[q]) begin
                        if (lcnt[q*NUM_PRI + int'(enq_pri)] == '0)
                            lhead[q*NUM_PRI + int'(enq_pri)] <= enq_slot;
                        ltail[q*NUM_PRI + int'(enq_pri)] <= enq_slot;
                        lcnt[q*NUM_PRI + int'(enq_pri)]  <= lcnt[q*NUM_PRI + int'(enq_pri)] + CNT_W'(1);
                        qlen[q] <= qlen[q] + CNT_W'(1);
                    end
                end
            end else if (deq_fire) begin
                lhead[dli]   <= qnxt[deq_q][lhead[dli]];
                lcnt[dli]    <= lcnt[dli] - CNT_W'(1);
                qlen[deq_q]  <= qlen[deq_q] - CNT_W'(1);
            end
        end
    end

    // Per-queue next pointers, no reset
    always_ff @(posedge clk) begin
        if (enq_fire) begin
            for (int q = 0; q < NUM_Q; q++) begin
                if (enq_acc[q] && (lcnt[q*NUM_PRI + int'(enq_pri)] != '0))
                    qnxt[q][ltail[q*NUM_PRI + int'(enq_pri)]] <= enq_slot;
            end
        end
    end

    // Reference counts, no reset: written on allocation before any read
    always_ff @(posedge clk) begin
        if (enq_fire)      refc[enq_slot] <= fanout;
        else if (deq_fire) refc[deq_head] <= refc[deq_head] - RC_W'(1);
    end

    for (genvar g = 0; g < NUM_Q; g++) begin : g_len
        assign qlen_flat[g*CNT_W +: CNT_W] = qlen[g];
        AST_QLEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            qlen[g] <= SLOTS_C); // R10
    end

    AST_DEQ_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        deq_fire |-> (lcnt[dli] != '0)); // R6
    AST_REF_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        deq_fire |-> (refc[deq_head] != '0)); // R7
    AST_ENQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(enq_fire && deq_fire)); // R5
endmodule

// File: rtl/cellq_mgr.sv
module cellq_mgr #(
    parameter int NUM_SLOTS = 512,
    parameter int NUM_Q     = 8,
    parameter int NUM_PRI   = 4,
    parameter int DROP_W    = 16,
    localparam int SLOT_W = $clog2(NUM_SLOTS),
    localparam int CNT_W  = $clog2(NUM_SLOTS + 1),
    localparam int Q_W    = $clog2(NUM_Q),
    localparam int P_W    = $clog2(NUM_PRI)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic signed [2:0]      share_shift,
    input  logic                   enq_valid,
    input  logic [NUM_Q-1:0]       enq_dest,
    input  logic [P_W-1:0]         enq_pri,
    output logic                   enq_done,
    output logic [NUM_Q-1:0]       enq_acc,
    output logic [SLOT_W-1:0]      enq_slot,
    input  logic                   deq_valid,
    input  logic [Q_W-1:0]         deq_queue,
    input  logic [P_W-1:0]         deq_pri,
    output logic                   deq_done,
    output logic                   deq_ok,
    output logic [SLOT_W-1:0]      deq_slot,
    output logic                   ready,
    output logic                   fault,
    output logic [CNT_W-1:0]       free_count,
    output logic [CNT_W-1:0]       used_count,
    output logic [NUM_Q*CNT_W-1:0] queue_len,
    output logic [DROP_W-1:0]      drop_count
);
    localparam logic [CNT_W-1:0] SLOTS_C = CNT_W'(NUM_SLOTS);

    logic              run, halted, build_push;
    logic [SLOT_W-1:0] build_slot, fl_head, l_head;
    logic [CNT_W-1:0]  fl_cnt;
    logic              fl_err, l_empty, rel;
    logic [NUM_Q-1:0]  acc;
    logic              enq_go, deq_go, enq_fire, deq_fire, deq_bad, fault_any;

    always_comb begin
        enq_go    = run && enq_valid;
        deq_go    = run && deq_valid && !enq_valid;
        enq_fire  = enq_go && (acc != '0);
        deq_fire  = deq_go && !l_empty;
        deq_bad   = deq_go && l_empty;
        fault_any = deq_bad || fl_err;
    end

    cellq_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .fault_in(fault_any),
        .build_push(build_push), .build_slot(build_slot),
        .run(run), .halted(halted)
    );

    cellq_freelist #(.NUM_SLOTS(NUM_SLOTS)) u_free (
        .clk(clk), .rst_n(rst_n),
        .push(build_push || rel),
        .push_slot(build_push ? build_slot : l_head),
        .pop(enq_fire),
        .head(fl_head), .cnt(fl_cnt), .err(fl_err)
    );

    cellq_admit #(.NUM_Q(NUM_Q), .CNT_W(CNT_W)) u_admit (
        .clk(clk), .rst_n(rst_n),
        .free_cnt(fl_cnt), .share_shift(share_shift),
        .qlen_flat(queue_len), .dest(enq_dest), .acc(acc)
    );

    cellq_links #(.NUM_SLOTS(NUM_SLOTS), .NUM_Q(NUM_Q), .NUM_PRI(NUM_PRI)) u_links (
        .clk(clk), .rst_n(rst_n),
        .enq_fire(enq_fire), .enq_slot(fl_head), .enq_acc(acc), .enq_pri(enq_pri),
        .deq_fire(deq_fire), .deq_q(deq_queue), .deq_p(deq_pri),
        .deq_head(l_head), .deq_empty(l_empty), .release_slot(rel),
        .qlen_flat(queue_len)
    );

    // Response and drop registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enq_done   <= 1'b0;
            enq_acc    <= '0;
            enq_slot   <= '0;
            deq_done   <= 1'b0;
            deq_ok     <= 1'b0;
            deq_slot   <= '0;
            drop_count <= '0;
        end else begin
            enq_done <= enq_go;
            enq_acc  <= enq_go ? acc : '0;
            enq_slot <= fl_head;
            deq_done <= deq_go;
            deq_ok   <= deq_fire;
            deq_slot <= l_head;
            if (enq_go && ((enq_dest & ~acc) != '0))
                drop_count <= drop_count + DROP_W'(1);
        end
    end

    assign ready      = run;
    assign fault      = halted;
    assign free_count = fl_cnt;
    assign used_count = SLOTS_C - fl_cnt;

    AST_ACC_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        enq_done |-> ((enq_acc & ~$past(enq_dest)) == '0)); // R2
    AST_SINGLE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        enq_fire |=> (free_count == $past(free_count) - CNT_W'(1))); // R2
    AST_RELEASE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_fire && rel) |=> (free_count == $past(free_count) + CNT_W'(1))); // R7
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (!enq_done && !deq_done)); // R9
    AST_EMPTY_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        deq_bad |=> (fault && deq_done && !deq_ok)); // R9
endmodule

// File: tb/sim_cellq_mgr.sv
module sim_cellq_mgr;
    localparam int NS = 512;
    localparam int NQ = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic signed [2:0] share_shift = 3'sd0;
    logic        enq_valid = 1'b0;
    logic [7:0]  enq_dest = '0;
    logic [1:0]  enq_pri = '0;
    logic        enq_done;
    logic [7:0]  enq_acc;
    logic [8:0]  enq_slot;
    logic        deq_valid = 1'b0;
    logic [2:0]  deq_queue = '0;
    logic [1:0]  deq_pri = '0;
    logic        deq_done, deq_ok;
    logic [8:0]  deq_slot;
    logic        ready, fault;
    logic [9:0]  free_count, used_count;
    logic [79:0] queue_len;
    logic [15:0] drop_count;

    always #10 clk = ~clk;

    cellq_mgr u0 (
        .clk(clk), .rst_n(rst_n), .share_shift(share_shift),
        .enq_valid(enq_valid), .enq_dest(enq_dest), .enq_pri(enq_pri),
        .enq_done(enq_done), .enq_acc(enq_acc), .enq_slot(enq_slot),
        .deq_valid(deq_valid), .deq_queue(deq_queue), .deq_pri(deq_pri),
        .deq_done(deq_done), .deq_ok(deq_ok), .deq_slot(deq_slot),
        .ready(ready), .fault(fault), .free_count(free_count),
        .used_count(used_count), .queue_len(queue_len), .drop_count(drop_count)
    );

    typedef struct {
        bit    is_enq;
        int    slot;
        int    acc;
        bit    ok;
        string req;
    } exp_t;

    exp_t  sb[$];
    int    fl[$];
    int    lq[32][$];
    int    rc[NS];
    int    qlen[NQ];
    int    drops = 0;
    bit    halted = 0;
    int    n_chk = 0;
    int    n_bad = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: pops expected responses as the design produces them
    always @(negedge clk) begin
        if (rst_n && (enq_done || deq_done)) begin
            if (sb.size() == 0) begin
                chk("R9 unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (e.is_enq) begin
                    chk({e.req, " enq_done"}, 32'(enq_done), 1);
                    chk({e.req, " enq_acc"}, 32'(enq_acc), e.acc);
                    if (e.acc != 0) chk({e.req, " enq_slot"}, 32'(enq_slot), e.slot);
                end else begin
                    chk({e.req, " deq_done"}, 32'(deq_done), 1);
                    chk({e.req, " deq_ok"}, 32'(deq_ok), 32'(e.ok));
                    if (e.ok) chk({e.req, " deq_slot"}, 32'(deq_slot), e.slot);
                end
            end
        end
    end

    task automatic do_enq(input int dest, input int pri, input string req);
        int fc, thr, acc, slot;
        exp_t e;
        @(negedge clk);
        enq_valid = 1'b1; enq_dest = 8'(dest); enq_pri = 2'(pri);
        if (!halted) begin
            fc  = fl.size();
            thr = (share_shift >= 0) ? (fc << int'(share_shift)) : (fc >> (-int'(share_shift)));
            acc = 0; slot = 0;
            for (int q = 0; q < NQ; q++)
                if (dest[q] && qlen[q] < thr) acc |= (1 << q);
            if ((dest & ~acc) != 0) drops++;
            if (acc != 0) begin
                slot = fl.pop_front();
                rc[slot] = $countones(acc);
                for (int q = 0; q < NQ; q++)
                    if (acc[q]) begin
                        lq[q*4 + pri].push_back(slot);
                        qlen[q]++;
                    end
            end
            e.is_enq = 1; e.slot = slot; e.acc = acc; e.ok = 1; e.req = req;
            sb.push_back(e);
        end
        @(negedge clk);
        enq_valid = 1'b0;
    endtask

    task automatic do_deq(input int q, input int pri, input string req);
        exp_t e;
        @(negedge clk);
        deq_valid = 1'b1; deq_queue = 3'(q); deq_pri = 2'(pri);
        if (!halted) begin
            e.is_enq = 0; e.acc = 0; e.req = req;
            if (lq[q*4 + pri].size() == 0) begin
                e.ok = 0; e.slot = 0;
                halted = 1;
            end else begin
                e.ok = 1;
                e.slot = lq[q*4 + pri].pop_front();
                rc[e.slot]--;
                if (rc[e.slot] == 0) fl.push_back(e.slot);
                qlen[q]--;
            end
            sb.push_back(e);
        end
        @(negedge clk);
        deq_valid = 1'b0;
    endtask

    task automatic check_status(input string req);
        chk({req, " free_count"}, 32'(free_count), fl.size());
        chk({req, " used_count R10"}, 32'(used_count), NS - fl.size());
        for (int q = 0; q < NQ; q++)
            chk({req, " queue_len R10"}, 32'(queue_len[q*10 +: 10]), qlen[q]);
        chk({req, " drop_count R4"}, 32'(drop_count), drops);
        chk({req, " fault"}, 32'(fault), 32'(halted));
    endtask

    initial begin
        #(20 * 150000);
        chk("watchdog expired", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n;
        for (int i = 0; i < NS; i++) fl.push_back(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: build phase length and reset state
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) chk("R1 ready low in build", 32'(ready), 0);
        end while (!ready && n < 2000);
        chk("R1 build cycles", n, NS);
        check_status("R1 reset");

        // R1/R2: ascending allocation, unicast
        share_shift = 3'sd0;
        for (int i = 0; i < 3; i++) do_enq(8'h01, 0, "R1 R2 unicast");
        // R2: multicast stored once
        do_enq(8'hA5, 2, "R2 multicast");
        check_status("R2 single copy");
        // R5: priorities independent
        do_enq(8'h02, 3, "R5 q1 p3");
        do_enq(8'h02, 0, "R5 q1 p0");
        do_deq(1, 0, "R5 p0 first");
        do_deq(1, 3, "R5 p3 after");
        // R6: FIFO order
        for (int i = 0; i < 3; i++) do_deq(0, 0, "R6 fifo");
        check_status("R6 lengths");
        // R7: multicast released only after the last copy
        do_deq(0, 2, "R7 copy q0");
        do_deq(2, 2, "R7 copy q2");
        do_deq(5, 2, "R7 copy q5");
        check_status("R7 still held");
        do_deq(7, 2, "R7 last copy");
        check_status("R7 released");

        // R3/R4: threshold at shift -2 on a single queue
        share_shift = -3'sd2;
        for (int i = 0; i < 110; i++) do_enq(8'h08, 1, "R3 shift -2");
        check_status("R3 R4 after shift -2 fill");
        // R3: shift +2 across queues 0..6, then queue 7
        share_shift = 3'sd2;
        for (int i = 0; i < 500; i++) do_enq(1 << (i % 7), 0, "R3 shift +2");
        for (int i = 0; i < 30; i++) do_enq(8'h80, 1, "R3 q7 fill");
        check_status("R3 R4 near full");
        // R4: fully refused multicast changes nothing
        do_enq(8'h7F, 2, "R4 refused");
        check_status("R4 no change");
        // R7: freed slots go to the tail of the free list
        do_deq(0, 0, "R7 drain a");
        do_deq(1, 0, "R7 drain b");
        for (int i = 0; i < 3; i++) do_enq(8'h80, 3, "R7 reuse order");
        check_status("R8 no fault under legal traffic");

        // R9: empty dequeue halts the block
        do_deq(6, 3, "R9 empty deq");
        check_status("R9 fault set");
        do_enq(8'h01, 0, "R9 halted enq");
        do_deq(3, 1, "R9 halted deq");
        repeat (2) @(negedge clk);
        check_status("R9 halted no change");
        chk("R2 R6 all responses seen", sb.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule